// File: doc/BRIEF.md
# Circular-Buffer Data Address Generator

This block produces 14-bit memory addresses for indirect operand fetches. It keeps four pointer registers, four modify registers and four length registers. In any cycle an access can name one pointer and one modify register. The named pointer, before any change, appears on the address output in that same cycle. At the next clock edge the pointer moves by the signed modify value.

When the pointer's length register is zero, the pointer advances linearly and wraps modulo 2^14. When the length is nonzero, the pointer stays inside a circular buffer that starts at the buffer base and holds that many words. Software therefore never has to check buffer bounds, and the same mechanism can feed automatic serial-port transfers to and from memory. Writing a pointer also records the written value as the base of that pointer's buffer.

A single register write port loads pointers, modifiers and lengths. The 2-bit kind field selects the register file and the 2-bit select field picks one of the four entries.

Top module: `dag_circ_addr`

## Requirements
- R1: While `accEn` is high, `addrOut` equals the selected pointer `accIdx` as it stood before this cycle's update, and `addrValid` is high. While `accEn` is low, `addrOut` is 0 and `addrValid` is low.
- R2: With length 0, an access leaves the pointer at (pointer + modify) modulo 2^14 after the clock edge.
- R3: With a nonzero length L and base B, a stepped value at or above B+L is reduced by L.
- R4: With a nonzero length L and base B, a stepped value below B is increased by L.
- R5: Each access may use any of the four modify registers, chosen by `accMod`. Modify values are 14-bit two's complement, so 0x3FFE means -2.
- R6: A write with `wrKind`=0 loads pointer `wrSel` and also sets that buffer's base to the written value. `wrKind`=1 loads modify register `wrSel`. `wrKind`=2 loads length register `wrSel`.
- R7: When a pointer write and a post-modify hit the same pointer in one cycle, the written value wins. The address output in that cycle still shows the old pointer.
- R8: An access changes only the pointer it selects.
- R9: After reset, every pointer, modifier, length and base is 0.
- R10: A write with `wrKind`=3 has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrKind | input | 2 | 0 pointer, 1 modify, 2 length, 3 none |
| wrSel | input | 2 | Register number to write |
| wrData | input | 14 | Write data |
| accEn | input | 1 | Indirect access strobe |
| accIdx | input | 2 | Pointer used for the access |
| accMod | input | 2 | Modify register used for the update |
| addrOut | output | 14 | Generated address |
| addrValid | output | 1 | Address valid, equal to `accEn` |

## Verification
The bench runs pointers across the upper and lower ends of a circular buffer. A design that compares the wrong way, or wraps by the wrong amount, would leave the buffer or skip words. It steps past 0x3FFF and below 0 with length zero, where a design that extends the sum wrongly would jump to a wrong address. It issues a pointer write and an access to the same pointer in one cycle, where a design with the priority reversed would drop the written value. It also mixes negative modifiers, the ignored write kind and a long random sequence, and checks that untouched pointers never move.

// File: rtl/dag_pkg.sv
package dag_pkg;
  parameter int AW   = 14;
  parameter int NPTR = 4;
  localparam int IDXW = $clog2(NPTR);

  typedef enum logic [1:0] {
    KIND_PTR  = 2'd0,
    KIND_MOD  = 2'd1,
    KIND_LEN  = 2'd2,
    KIND_NONE = 2'd3
  } regKind_e;

  typedef struct packed {
    logic [NPTR-1:0] ptrLoad;
    logic [NPTR-1:0] ptrStep;
    logic [NPTR-1:0] modLoad;
    logic [NPTR-1:0] lenLoad;
    logic [IDXW-1:0] modSel;
  } dagStrobe_t;
endpackage

// File: rtl/dag_ctrl.sv
module dag_ctrl
  import dag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [1:0]       wrKind,
  input  logic [IDXW-1:0]  wrSel,
  input  logic             accEn,
  input  logic [IDXW-1:0]  accIdx,
  input  logic [IDXW-1:0]  accMod,
  output dagStrobe_t       strobe
);
  logic [NPTR-1:0] wrOneHot;
  logic [NPTR-1:0] accOneHot;
  regKind_e        kind;

  assign kind = regKind_e'(wrKind);

  always_comb begin
    wrOneHot  = '0;
    accOneHot = '0;
    wrOneHot[wrSel]   = wrEn;
    accOneHot[accIdx] = accEn;
  end

  always_comb begin
    strobe.ptrLoad = (kind == KIND_PTR) ? wrOneHot : '0;
    strobe.modLoad = (kind == KIND_MOD) ? wrOneHot : '0;
    strobe.lenLoad = (kind == KIND_LEN) ? wrOneHot : '0;
    // write has priority over post-modify on the same pointer
    strobe.ptrStep = accOneHot & ~strobe.ptrLoad;
    strobe.modSel  = accMod;
  end

  // R1
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe.ptrStep));

  // R10
  none_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrKind == 2'd3) |-> ((strobe.ptrLoad | strobe.modLoad | strobe.lenLoad) == '0));
endmodule

// File: rtl/dag_datapath.sv
module dag_datapath
  import dag_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  dagStrobe_t      strobe,
  input  logic [AW-1:0]   wrData,
  input  logic            accEn,
  input  logic [IDXW-1:0] accIdx,
  output logic [AW-1:0]   addrOut,
  output logic            addrValid
);
  localparam int EW = AW + 2;

  logic [AW-1:0] ptrReg  [NPTR];
  logic [AW-1:0] baseReg [NPTR];
  logic [AW-1:0] modReg  [NPTR];
  logic [AW-1:0] lenReg  [NPTR];
  logic [AW-1:0] modVal;

  assign modVal    = modReg[strobe.modSel];
  assign addrOut   = accEn ? ptrReg[accIdx] : '0;
  assign addrValid = accEn;

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    logic signed [EW-1:0] sumS;
    logic signed [EW-1:0] lowS;
    logic signed [EW-1:0] highS;
    logic signed [EW-1:0] lenS;
    logic signed [EW-1:0] wrapS;
    logic [AW-1:0]        nextPtr;

    always_comb begin
      sumS  = $signed({2'b00, ptrReg[i]}) + $signed({{2{modVal[AW-1]}}, modVal});
      lowS  = $signed({2'b00, baseReg[i]});
      lenS  = $signed({2'b00, lenReg[i]});
      highS = lowS + lenS;
      wrapS = sumS;
      if (lenReg[i] != '0) begin
        if (sumS >= highS)     wrapS = sumS - lenS;
        else if (sumS < lowS)  wrapS = sumS + lenS;
      end
      nextPtr = wrapS[AW-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ptrReg[i]  <= '0;
        baseReg[i] <= '0;
        modReg[i]  <= '0;
        lenReg[i]  <= '0;
      end else begin
        if (strobe.ptrLoad[i]) begin
          ptrReg[i]  <= wrData;
          baseReg[i] <= wrData;
        end else if (strobe.ptrStep[i]) begin
          ptrReg[i]  <= nextPtr;
        end
        if (strobe.modLoad[i]) modReg[i] <= wrData;
        if (strobe.lenLoad[i]) lenReg[i] <= wrData;
      end
    end

    // R3 R4
    in_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe.ptrStep[i] && lenReg[i] != '0 && ptrReg[i] >= baseReg[i]
       && ({2'b00, ptrReg[i]} < {2'b00, baseReg[i]} + {2'b00, lenReg[i]})
       && ({2'b00, baseReg[i]} + {2'b00, lenReg[i]} <= (1 << AW)))
      |=> (ptrReg[i] >= $past(baseReg[i]) &&
           {2'b00, ptrReg[i]} < {2'b00, $past(baseReg[i])} + {2'b00, $past(lenReg[i])}));

    // R6 R7
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe.ptrLoad[i] |=> (ptrReg[i] == $past(wrData) && baseReg[i] == $past(wrData)));

    // R8
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe.ptrLoad[i] && !strobe.ptrStep[i]) |=> $stable(ptrReg[i]));
  end
endmodule

// File: rtl/dag_circ_addr.sv
module dag_circ_addr
  import dag_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wrEn,
  input  logic [1:0]      wrKind,
  input  logic [IDXW-1:0] wrSel,
  input  logic [AW-1:0]   wrData,
  input  logic            accEn,
  input  logic [IDXW-1:0] accIdx,
  input  logic [IDXW-1:0] accMod,
  output logic [AW-1:0]   addrOut,
  output logic            addrValid
);
  dagStrobe_t strobe;

  dag_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrKind(wrKind), .wrSel(wrSel),
    .accEn(accEn), .accIdx(accIdx), .accMod(accMod), .strobe(strobe)
  );

  dag_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrData(wrData),
    .accEn(accEn), .accIdx(accIdx), .addrOut(addrOut), .addrValid(addrValid)
  );

  // R1
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addrValid == accEn);
endmodule

// File: tb/tb_dag_circ_addr.sv
module tb_dag_circ_addr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrKind = 2'd0;
  logic [1:0]  wrSel = 2'd0;
  logic [13:0] wrData = 14'd0;
  logic        accEn = 1'b0;
  logic [1:0]  accIdx = 2'd0;
  logic [1:0]  accMod = 2'd0;
  logic [13:0] addrOut;
  logic        addrValid;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  int mP [4];
  int mB [4];
  int mM [4];
  int mL [4];

  always #10 clk = ~clk;

  dag_circ_addr dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrKind(wrKind), .wrSel(wrSel),
    .wrData(wrData), .accEn(accEn), .accIdx(accIdx), .accMod(accMod),
    .addrOut(addrOut), .addrValid(addrValid)
  );

  task automatic step(input bit we, input int kind, input int sel, input int data,
                      input bit ae, input int ai, input int am, input string req);
    int expA;
    int s;
    int m;
    wrEn = we; wrKind = 2'(kind); wrSel = 2'(sel); wrData = 14'(data);
    accEn = ae; accIdx = 2'(ai); accMod = 2'(am);
    #2;
    expA = ae ? mP[ai] : 0;
    vectors++;
    if (addrOut !== 14'(expA) || addrValid !== ae) begin
      errors++;
      $display("FAIL %s: addrOut=%0h valid=%0b expected addrOut=%0h valid=%0b",
               req, addrOut, addrValid, expA, ae);
    end
    if (ae) begin
      m = mM[am];
      if (m >= 8192) m -= 16384;
      s = mP[ai] + m;
      if (mL[ai] != 0) begin
        if (s >= mB[ai] + mL[ai]) s -= mL[ai];
        else if (s < mB[ai]) s += mL[ai];
      end
      mP[ai] = s & 16383;
    end
    if (we) begin
      case (kind)
        0: begin mP[sel] = data & 16383; mB[sel] = data & 16383; end
        1: mM[sel] = data & 16383;
        2: mL[sel] = data & 16383;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int kind, input int sel, input int data, input string req);
    step(1'b1, kind, sel, data, 1'b0, 0, 0, req);
  endtask

  task automatic acc(input int ai, input int am, input string req);
    step(1'b0, 0, 0, 0, 1'b1, ai, am, req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mP[i] = 0; mB[i] = 0; mM[i] = 0; mL[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state, every pointer reads 0, stepping with zero modifiers
    for (int i = 0; i < 4; i++) acc(i, i, "R9");
    step(1'b0, 0, 0, 0, 1'b0, 0, 0, "R1");
    // R6: load pointers and modifiers
    wr(0, 0, 100, "R6");
    wr(0, 1, 200, "R6");
    wr(0, 2, 14'h3FF0, "R6");
    wr(0, 3, 50, "R6");
    wr(1, 0, 3, "R6");
    wr(1, 1, 14'h3FFE, "R6");
    wr(1, 2, 1, "R6");
    wr(1, 3, 5, "R6");
    // R2: linear stepping across the top of the address space
    for (int k = 0; k < 5; k++) acc(2, 3, "R2");
    // R2: linear stepping below zero
    wr(0, 3, 3, "R2");
    for (int k = 0; k < 4; k++) acc(3, 1, "R2");
    // R3: circular buffer base 100, length 10, step +3
    wr(2, 0, 10, "R3");
    wr(0, 0, 100, "R3");
    for (int k = 0; k < 8; k++) acc(0, 0, "R3");
    // R4: circular buffer base 200, length 8, step -2
    wr(2, 1, 8, "R4");
    wr(0, 1, 200, "R4");
    for (int k = 0; k < 8; k++) acc(1, 1, "R4");
    // R5: alternate modifier choices on one circular pointer
    for (int k = 0; k < 8; k++) acc(0, k % 4, "R5");
    // R8: pointers not selected stay put
    for (int i = 0; i < 4; i++) acc(i, 2, "R8");
    // R7: same-cycle write and access to pointer 0
    step(1'b1, 0, 0, 104, 1'b1, 0, 0, "R7");
    acc(0, 0, "R7");
    acc(0, 0, "R7");
    // R10: ignored write kind, then observe all pointers
    step(1'b1, 3, 1, 14'h1234, 1'b0, 0, 0, "R10");
    step(1'b1, 3, 2, 14'h0777, 1'b0, 0, 0, "R10");
    for (int i = 0; i < 4; i++) acc(i, 2, "R10");
    for (int i = 0; i < 4; i++) acc(i, 0, "R10");
    // random phase: length 16 buffers, modifiers within +/-15
    for (int i = 0; i < 4; i++) begin
      wr(2, i, 16, "R3");
      wr(0, i, int'($urandom_range(0, 2000)), "R6");
      wr(1, i, (int'($urandom_range(0, 30)) - 15) & 16383, "R5");
    end
    for (int k = 0; k < 600; k++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r == 0)
        step(1'b1, 0, int'($urandom_range(0, 3)), int'($urandom_range(0, 2000)),
             1'b1, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), "R7");
      else if (r == 1)
        wr(1, int'($urandom_range(0, 3)), (int'($urandom_range(0, 30)) - 15) & 16383, "R5");
      else if (r == 2)
        step(1'b0, 0, 0, 0, 1'b0, 0, 0, "R1");
      else
        acc(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), "R4");
    end
    for (int i = 0; i < 4; i++) acc(i, 0, "R8");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule